// File: doc/BRIEF.md
# Display Scan Timing Generator with Deferred Framebuffer Flip

This block drives one display pipe. It keeps a horizontal and a vertical pixel counter that run against programmable totals. From those counters it produces horizontal sync, vertical sync and a data-enable signal. Each sync has its own window, enable and polarity. The block also publishes the current scan coordinates and a running count of vertical blanking intervals.

Two framebuffer base addresses are held, and one of them is presented as the live scan-out base. Software requests a swap by writing a trigger bit. The request stays pending until the first pixel clock of the next vertical blanking interval, and the live selection toggles there. Software can therefore rewrite the idle base address and queue a flip without tearing the frame on screen.

A flat word-addressed register bus (write strobe, 4-bit word index, 32-bit data) programs the block. A combinational read port returns the configuration and the status.

Top module: `dpt_pipe`

Register map by word index. 0 is CTRL. 1 is HSIZE: active width in [12:0], total in [28:16]. 2 is HSYNC: start in [12:0], end in [28:16], enable in bit 30, invert in bit 31. 3 is VSIZE: active height in [11:0], total in [27:16]. 4 is VSYNC: start in [11:0], end in [27:16], enable in bit 30, invert in bit 31. 5 is FB0. 6 is FB1. 7 is SCAN, read only. 8 is VBCOUNT, read only. All other indices read as zero.

CTRL fields:
- bit 7: flip trigger on write; reads back as the pending flag.
- bit 8: output enable.
- bit 11: live selector, read only.
- bit 20: active-low pipe run/reset.

## Requirements
- R1: While running, X counts 0..HTOTAL-1 and then wraps to 0. Y advances by one on each X wrap and wraps to 0 after VTOTAL-1. Reading word 7 returns X in bits [31:16] and Y in bits [15:0].
- R2: `de` is 1 exactly when the pipe runs, X < HACTIVE and Y < VACTIVE.
- R3: `hsync` equals the HSYNC invert bit (31) XOR (running AND enable bit 30 AND start <= X < end). With enable clear, the output sits constant at the invert level.
- R4: `vsync` follows the same rule as R3, using the VSYNC word and Y.
- R5: The pipe runs only while CTRL bit 8 and CTRL bit 20 are both 1. Otherwise X and Y are held at 0 and `de` is 0.
- R6: Writing CTRL with bit 7 set makes the flip pending, and CTRL bit 7 reads back as 1. At the clock edge that ends the pixel X=0, Y=VACTIVE, a pending flip toggles the live selector and clears the pending flag in the same edge.
- R7: Each trigger produces at most one toggle. Several triggers before one vblank give a single toggle, and a vblank with nothing pending leaves the selector unchanged.
- R8: `fb_base` shows FB0 while the selector is 0 and FB1 while it is 1. CTRL bit 11 reads the selector.
- R9: `vblank_cnt` (also word 8) increments at the clock edge that ends each pixel X=0, Y=VACTIVE.
- R10: A CTRL write that clears bit 20 while bit 20 is stored as 1 is a soft reset. It zeroes X, Y, the vblank count, the selector and the pending flag.
- R11: After `rst_n`, CTRL reads 0x00100000, all other words read 0, and `de`, `hsync` and `vsync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| scan_x | output | HW (13) | Current X position |
| scan_y | output | VW (12) | Current Y position |
| fb_base | output | AW (32) | Live framebuffer base address |
| vblank_cnt | output | CW (32) | Number of vblank starts |

## Verification
A register write takes effect at the edge that accepts it. The first running edge moves X from 0 to 1, so once the enable write is accepted, the sample taken k falling edges later must show position k. The sync and data-enable outputs are decoded combinationally from the counters, so they are due in that same sample. The selector, pending flag and vblank count change one edge after the pixel X=0, Y=VACTIVE, so the checks sample that pixel (old values) and the pixel after it (new values). All sampling happens on falling edges, with a running pixel index kept in the bench.

// File: rtl/dpt_pkg.sv
// Package: register word indices and field positions of the scan timing
// generator, shared by the register file and the bench-facing documentation.
package dpt_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 4'd0,
        RA_HSIZE = 4'd1,
        RA_HSYNC = 4'd2,
        RA_VSIZE = 4'd3,
        RA_VSYNC = 4'd4,
        RA_FB0   = 4'd5,
        RA_FB1   = 4'd6,
        RA_SCAN  = 4'd7,
        RA_VBCNT = 4'd8
    } reg_addr_e;

    localparam int CTRL_FLIP_BIT = 7;
    localparam int CTRL_OE_BIT   = 8;
    localparam int CTRL_SEL_BIT  = 11;
    localparam int CTRL_RUNN_BIT = 20;
    localparam int SYNC_EN_BIT   = 30;
    localparam int SYNC_INV_BIT  = 31;
    localparam int HI_LSB        = 16;

endpackage

// File: rtl/dpt_regs.sv
// Module: dpt_regs
// Holds the writable configuration words and decodes the CTRL side effects
// (flip trigger, soft reset). Returns read data combinationally.
// Assumes HW, VW <= 16 and AW, CW <= 32, so every field fits a 32-bit word.
module dpt_regs
    import dpt_pkg::*;
#(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              live_sel,
    input  logic              flip_pend,
    input  logic [HW-1:0]     scan_x,
    input  logic [VW-1:0]     scan_y,
    input  logic [CW-1:0]     vblank_cnt,
    output logic              run,
    output logic              flip_wr,
    output logic              soft_rst,
    output logic [HW-1:0]     hact,
    output logic [HW-1:0]     htot,
    output logic [HW-1:0]     hs_start,
    output logic [HW-1:0]     hs_end,
    output logic              hs_en,
    output logic              hs_inv,
    output logic [VW-1:0]     vact,
    output logic [VW-1:0]     vtot,
    output logic [VW-1:0]     vs_start,
    output logic [VW-1:0]     vs_end,
    output logic              vs_en,
    output logic              vs_inv,
    output logic [AW-1:0]     fb0,
    output logic [AW-1:0]     fb1
);

    logic oe_q;
    logic runn_q;
    logic ctrl_wr;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign ctrl_wr      = reg_we && (reg_addr == RA_CTRL);
    assign flip_wr      = ctrl_wr && reg_wdata[CTRL_FLIP_BIT];
    assign soft_rst     = ctrl_wr && runn_q && !reg_wdata[CTRL_RUNN_BIT];
    assign run          = oe_q && runn_q;

    // Capture register writes; run/reset bit comes out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q     <= 1'b0;
            runn_q   <= 1'b1;
            hact     <= '0;
            htot     <= '0;
            hs_start <= '0;
            hs_end   <= '0;
            hs_en    <= 1'b0;
            hs_inv   <= 1'b0;
            vact     <= '0;
            vtot     <= '0;
            vs_start <= '0;
            vs_end   <= '0;
            vs_en    <= 1'b0;
            vs_inv   <= 1'b0;
            fb0      <= '0;
            fb1      <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    oe_q   <= reg_wdata[CTRL_OE_BIT];
                    runn_q <= reg_wdata[CTRL_RUNN_BIT];
                end
                RA_HSIZE: begin
                    hact <= reg_wdata[HW-1:0];
                    htot <= reg_wdata[HI_LSB +: HW];
                end
                RA_HSYNC: begin
                    hs_start <= reg_wdata[HW-1:0];
                    hs_end   <= reg_wdata[HI_LSB +: HW];
                    hs_en    <= reg_wdata[SYNC_EN_BIT];
                    hs_inv   <= reg_wdata[SYNC_INV_BIT];
                end
                RA_VSIZE: begin
                    vact <= reg_wdata[VW-1:0];
                    vtot <= reg_wdata[HI_LSB +: VW];
                end
                RA_VSYNC: begin
                    vs_start <= reg_wdata[VW-1:0];
                    vs_end   <= reg_wdata[HI_LSB +: VW];
                    vs_en    <= reg_wdata[SYNC_EN_BIT];
                    vs_inv   <= reg_wdata[SYNC_INV_BIT];
                end
                RA_FB0:  fb0 <= reg_wdata[AW-1:0];
                RA_FB1:  fb1 <= reg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer over configuration and status words.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTRL_FLIP_BIT] = flip_pend;
                reg_rdata[CTRL_OE_BIT]   = oe_q;
                reg_rdata[CTRL_SEL_BIT]  = live_sel;
                reg_rdata[CTRL_RUNN_BIT] = runn_q;
            end
            RA_HSIZE: begin
                reg_rdata[HW-1:0]       = hact;
                reg_rdata[HI_LSB +: HW] = htot;
            end
            RA_HSYNC: begin
                reg_rdata[HW-1:0]        = hs_start;
                reg_rdata[HI_LSB +: HW]  = hs_end;
                reg_rdata[SYNC_EN_BIT]   = hs_en;
                reg_rdata[SYNC_INV_BIT]  = hs_inv;
            end
            RA_VSIZE: begin
                reg_rdata[VW-1:0]       = vact;
                reg_rdata[HI_LSB +: VW] = vtot;
            end
            RA_VSYNC: begin
                reg_rdata[VW-1:0]        = vs_start;
                reg_rdata[HI_LSB +: VW]  = vs_end;
                reg_rdata[SYNC_EN_BIT]   = vs_en;
                reg_rdata[SYNC_INV_BIT]  = vs_inv;
            end
            RA_FB0:   reg_rdata[AW-1:0] = fb0;
            RA_FB1:   reg_rdata[AW-1:0] = fb1;
            RA_SCAN: begin
                reg_rdata[HI_LSB +: HW] = scan_x;
                reg_rdata[VW-1:0]       = scan_y;
            end
            RA_VBCNT: reg_rdata[CW-1:0] = vblank_cnt;
            default:  ;
        endcase
    end

endmodule

// File: rtl/dpt_scan.sv
// Module: dpt_scan
// Raster position counters. X wraps at htot-1, and Y steps on each X wrap
// and wraps at vtot-1. Both are held at zero while not running or on a
// soft reset. Assumes totals are programmed before running is enabled.
module dpt_scan #(
    parameter int HW = 13,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          soft_rst,
    input  logic [HW-1:0] htot,
    input  logic [VW-1:0] vtot,
    output logic [HW-1:0] scan_x,
    output logic [VW-1:0] scan_y
);

    localparam logic [HW-1:0] HONE = HW'(1);
    localparam logic [VW-1:0] VONE = VW'(1);

    logic x_last;
    logic y_last;

    assign x_last = (scan_x >= htot - HONE);
    assign y_last = (scan_y >= vtot - VONE);

    // Advance the raster position one pixel per clock while running.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !run) begin
            scan_x <= '0;
            scan_y <= '0;
        end else if (x_last) begin
            scan_x <= '0;
            scan_y <= y_last ? '0 : scan_y + VONE;
        end else begin
            scan_x <= scan_x + HONE;
        end
    end

endmodule

// File: rtl/dpt_sync_gen.sv
// Module: dpt_sync_gen
// One axis of sync decode: a half-open [start, end) window, gated by enable
// and running, XORed with the polarity bit. Also flags the active region.
// Purely combinational; assumes the position input is registered upstream.
module dpt_sync_gen #(
    parameter int W = 13
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] act,
    input  logic [W-1:0] win_start,
    input  logic [W-1:0] win_end,
    input  logic         en,
    input  logic         inv,
    input  logic         run,
    output logic         sync,
    output logic         in_act
);

    logic in_win;

    // Decode the sync window and the active region for this axis.
    always_comb begin
        in_win = (pos >= win_start) && (pos < win_end);
        sync   = inv ^ (run && en && in_win);
        in_act = (pos < act);
    end

endmodule

// File: rtl/dpt_flip.sv
// Module: dpt_flip
// Double-buffered base selection. A trigger sets a pending flag, and the
// first vblank pixel with the flag set toggles the live selector and clears
// the flag. Also counts vblank starts. Assumes vbl_start is one cycle wide.
module dpt_flip #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          flip_wr,
    input  logic          vbl_start,
    input  logic [AW-1:0] fb0,
    input  logic [AW-1:0] fb1,
    output logic          live_sel,
    output logic          flip_pend,
    output logic [AW-1:0] fb_base,
    output logic [CW-1:0] vblank_cnt
);

    // Hold the flip request and swap the selector at vblank start.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            live_sel  <= 1'b0;
            flip_pend <= 1'b0;
        end else begin
            if (vbl_start && flip_pend) begin
                live_sel <= ~live_sel;
            end
            flip_pend <= (flip_pend && !vbl_start) || flip_wr;
        end
    end

    // Count every vblank start.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            vblank_cnt <= '0;
        end else if (vbl_start) begin
            vblank_cnt <= vblank_cnt + CW'(1);
        end
    end

    assign fb_base = live_sel ? fb1 : fb0;

endmodule

// File: rtl/dpt_pipe.sv
// Module: dpt_pipe (top)
// Display scan timing generator with a deferred framebuffer flip. Ties the
// register file, raster counters, per-axis sync decode and flip logic.
// Assumes a single pixel clock domain and a synchronous active-low reset.
module dpt_pipe
    import dpt_pkg::*;
#(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [HW-1:0]     scan_x,
    output logic [VW-1:0]     scan_y,
    output logic [AW-1:0]     fb_base,
    output logic [CW-1:0]     vblank_cnt
);

    logic          run, flip_wr, soft_rst, vbl_start;
    logic          live_sel, flip_pend;
    logic [HW-1:0] hact, htot, hs_start, hs_end;
    logic [VW-1:0] vact, vtot, vs_start, vs_end;
    logic          hs_en, hs_inv, vs_en, vs_inv;
    logic [AW-1:0] fb0, fb1;
    logic          h_act, v_act;

    dpt_regs #(.HW(HW), .VW(VW), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .live_sel(live_sel), .flip_pend(flip_pend),
        .scan_x(scan_x), .scan_y(scan_y), .vblank_cnt(vblank_cnt),
        .run(run), .flip_wr(flip_wr), .soft_rst(soft_rst),
        .hact(hact), .htot(htot), .hs_start(hs_start), .hs_end(hs_end),
        .hs_en(hs_en), .hs_inv(hs_inv),
        .vact(vact), .vtot(vtot), .vs_start(vs_start), .vs_end(vs_end),
        .vs_en(vs_en), .vs_inv(vs_inv),
        .fb0(fb0), .fb1(fb1)
    );

    dpt_scan #(.HW(HW), .VW(VW)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(run), .soft_rst(soft_rst),
        .htot(htot), .vtot(vtot), .scan_x(scan_x), .scan_y(scan_y)
    );

    dpt_sync_gen #(.W(HW)) u_hsync (
        .pos(scan_x), .act(hact), .win_start(hs_start), .win_end(hs_end),
        .en(hs_en), .inv(hs_inv), .run(run), .sync(hsync), .in_act(h_act)
    );

    dpt_sync_gen #(.W(VW)) u_vsync (
        .pos(scan_y), .act(vact), .win_start(vs_start), .win_end(vs_end),
        .en(vs_en), .inv(vs_inv), .run(run), .sync(vsync), .in_act(v_act)
    );

    // First pixel of vertical blanking, and the active-area enable.
    always_comb begin
        vbl_start = run && (scan_x == '0) && (scan_y == vact);
        de        = run && h_act && v_act;
    end

    dpt_flip #(.AW(AW), .CW(CW)) u_flip (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flip_wr(flip_wr),
        .vbl_start(vbl_start), .fb0(fb0), .fb1(fb1),
        .live_sel(live_sel), .flip_pend(flip_pend),
        .fb_base(fb_base), .vblank_cnt(vblank_cnt)
    );

endmodule

// File: rtl/dpt_pipe_chk.sv
// Module: dpt_pipe_chk
// Temporal checks on the scan counters and the flip logic, attached to the
// top module by the bind statement at the end of this file.
module dpt_pipe_chk #(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          soft_rst,
    input logic          flip_wr,
    input logic          vbl_start,
    input logic          flip_pend,
    input logic          live_sel,
    input logic [HW-1:0] scan_x,
    input logic [VW-1:0] scan_y,
    input logic [CW-1:0] vblank_cnt
);

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && scan_x != '0) |-> (scan_x - $past(scan_x)) == HW'(1)); // R1
    AST_Y_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && scan_y != $past(scan_y)) |-> scan_x == '0); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (scan_x == '0 && scan_y == '0)); // R5
    AST_SEL_AT_VBL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_sel) |-> ($past(vbl_start && flip_pend) || $past(soft_rst))); // R6
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (vbl_start && flip_pend && !flip_wr && !soft_rst) |=> !flip_pend); // R7
    AST_VBCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank_cnt) |-> ($past(vbl_start) || $past(soft_rst))); // R9

endmodule

bind dpt_pipe dpt_pipe_chk #(.HW(HW), .VW(VW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .soft_rst(soft_rst),
    .flip_wr(flip_wr), .vbl_start(vbl_start), .flip_pend(flip_pend),
    .live_sel(live_sel), .scan_x(scan_x), .scan_y(scan_y),
    .vblank_cnt(vblank_cnt)
);

// File: tb/tb_dpt_pipe.sv
`timescale 1ns/1ps
module tb_dpt_pipe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        hsync, vsync, de;
    logic [12:0] scan_x;
    logic [11:0] scan_y;
    logic [31:0] fb_base, vblank_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int kcur  = 0;
    bit done  = 0;

    localparam logic [31:0] FBA = 32'hA000_0000;
    localparam logic [31:0] FBB = 32'hB000_0000;

    // {pixel index k, x, y, de, hsync, vsync} for 10x6 total, 6x4 active,
    // hsync window [7,9), vsync window [4,5).
    localparam logic [18:0] VEC [0:12] = '{
        {8'd0,  4'd0, 4'd0, 1'b1, 1'b0, 1'b0},
        {8'd5,  4'd5, 4'd0, 1'b1, 1'b0, 1'b0},
        {8'd6,  4'd6, 4'd0, 1'b0, 1'b0, 1'b0},
        {8'd7,  4'd7, 4'd0, 1'b0, 1'b1, 1'b0},
        {8'd8,  4'd8, 4'd0, 1'b0, 1'b1, 1'b0},
        {8'd9,  4'd9, 4'd0, 1'b0, 1'b0, 1'b0},
        {8'd10, 4'd0, 4'd1, 1'b1, 1'b0, 1'b0},
        {8'd43, 4'd3, 4'd4, 1'b0, 1'b0, 1'b1},
        {8'd47, 4'd7, 4'd4, 1'b0, 1'b1, 1'b1},
        {8'd50, 4'd0, 4'd5, 1'b0, 1'b0, 1'b0},
        {8'd59, 4'd9, 4'd5, 1'b0, 1'b0, 1'b0},
        {8'd60, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0},
        {8'd63, 4'd3, 4'd0, 1'b1, 1'b0, 1'b0}
    };

    dpt_pipe dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .scan_x(scan_x), .scan_y(scan_y),
        .fb_base(fb_base), .vblank_cnt(vblank_cnt)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s k=%0d actual=%h expected=%h", req, kcur, act, exp);
        end
    endtask

    // Called at a falling edge; the write is taken at the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        kcur++;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step_to(input int k);
        while (kcur < k) begin
            @(negedge clk);
            kcur++;
        end
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        rd(4'd0, r);  chk("R11 ctrl", r, 32'h0010_0000);
        rd(4'd2, r);  chk("R11 hsync word", r, 32'd0);
        chk("R11 outputs", {29'd0, de, hsync, vsync}, 32'd0);
        chk("R11 vblank", vblank_cnt, 32'd0);
        // Program while disabled
        wr(4'd1, 32'h000A_0006);
        wr(4'd2, 32'h4009_0007);
        wr(4'd3, 32'h0006_0004);
        wr(4'd4, 32'h4005_0004);
        wr(4'd5, FBA);
        wr(4'd6, FBB);
        chk("R5 idle x", {19'd0, scan_x}, 32'd0);
        chk("R5 idle de", {31'd0, de}, 32'd0);
        chk("R8 base fb0", fb_base, FBA);
        // Enable: first sample after this write is pixel 0
        wr(4'd0, 32'h0010_0100);
        kcur = 0;
        for (int i = 0; i < 13; i++) begin
            step_to(int'(VEC[i][18:11]));
            chk("R1 x", {19'd0, scan_x}, {28'd0, VEC[i][10:7]});
            chk("R1 y", {20'd0, scan_y}, {28'd0, VEC[i][6:3]});
            chk("R2 de", {31'd0, de}, {31'd0, VEC[i][2]});
            chk("R3 hsync", {31'd0, hsync}, {31'd0, VEC[i][1]});
            chk("R4 vsync", {31'd0, vsync}, {31'd0, VEC[i][0]});
        end
        rd(4'd7, r);  chk("R1 scan word", r, 32'h0003_0000);
        rd(4'd8, r);  chk("R9 count word", r, 32'd1);
        // Flip request, then the next vblank start at pixel 100
        wr(4'd0, 32'h0010_0180);
        rd(4'd0, r);  chk("R6 pending", r, 32'h0010_0180);
        step_to(100);
        chk("R6 before swap", fb_base, FBA);
        chk("R9 before", vblank_cnt, 32'd1);
        step_to(101);
        chk("R8 after swap", fb_base, FBB);
        rd(4'd0, r);  chk("R6 sel/pend", r, 32'h0010_0900);
        chk("R9 after", vblank_cnt, 32'd2);
        step_to(161);
        chk("R7 no trigger", fb_base, FBB);
        chk("R9 third", vblank_cnt, 32'd3);
        wr(4'd0, 32'h0010_0180);
        wr(4'd0, 32'h0010_0180);
        step_to(221);
        chk("R7 double trigger", fb_base, FBA);
        // Polarity and enable
        wr(4'd2, 32'hC009_0007);
        chk("R3 inverted idle", {31'd0, hsync}, 32'd1);
        step_to(227);
        chk("R3 inverted window", {31'd0, hsync}, 32'd0);
        wr(4'd4, 32'h0005_0004);
        chk("R4 disabled in window", {31'd0, vsync}, 32'd0);
        // Soft reset with selector at 1
        wr(4'd0, 32'h0010_0180);
        step_to(281);
        chk("R8 pre soft reset", fb_base, FBB);
        wr(4'd0, 32'h0000_0100);
        chk("R10 x/y", {7'd0, scan_x, scan_y}, 32'd0);
        chk("R10 count", vblank_cnt, 32'd0);
        chk("R10 base", fb_base, FBA);
        rd(4'd0, r);  chk("R10 ctrl", r, 32'h0000_0100);
        step_to(kcur + 3);
        chk("R5 held", {19'd0, scan_x}, 32'd0);
        wr(4'd0, 32'h0010_0100);
        kcur = 0;
        step_to(5);
        chk("R5 resumed", {19'd0, scan_x}, 32'd5);
        chk("R2 resumed de", {31'd0, de}, 32'd1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule